// File: doc/BRIEF.md
# Predicate Disjointness Tracker

This block sits beside the issue logic of an in-order pipeline that runs if-converted code. It records which predicate definitions are mutually exclusive, so the dependence check can drop a hazard between two instructions that can never both commit. Each compare event names two destination predicates and a guard predicate. The block gives every destination its own path entry. It stores a disjointness bit vector per entry in a square bit matrix. It also keeps a map from each architectural predicate register to the entry of that register's latest definition.

An unguarded compare marks its two new entries as exclusive of each other. A guarded compare first takes a copy of the guard's current disjointness vector into both new entries and then adds the pair bit. In this way exclusivity carries down through nested if-converted regions.

Entries are handed out in pairs from a wrapping pointer. When an entry is handed out again, its row and its column are wiped in that same cycle. The query port takes two entry indices and returns a combinational flag read from the registered matrix. The entry count must be a power of two and at least 2. Predicate register 0 is the always-true predicate. It is never recorded in the map, and guarding a compare with it means the compare is unguarded.

Top module: `pred_disjoint_table`

## Requirements
- R1: After reset, every query returns 0 and the allocator offers entries 0 and 1.
- R2: An accepted compare (cmp_valid_i=1) is assigned entry P on alloc_a_o and entry P+1 on alloc_b_o, where P is the current even pointer. P then advances by 2 modulo the entry count. On cycles with no compare, the pointer holds.
- R3: After an unguarded compare, its two entries query as disjoint from each other and from no other entry.
- R4: After a compare guarded by predicate g, both new entries are disjoint from every entry that g's current definition was disjoint from, and also from each other.
- R5: query(i,j) always equals query(j,i), and query(i,i) is always 0.
- R6: When an entry is reassigned, all of its old disjointness relations, in both directions, are dropped in the allocation cycle before any new ones are added.
- R7: A compare records alloc_a_o as the definition of destination a and alloc_b_o as the definition of destination b. If both destinations name the same register, b wins. Predicate 0 is never recorded.
- R8: A compare whose guard is predicate 0, or a predicate that has never been defined since reset, behaves exactly as unguarded.
- R9: The guard is looked up in the map as it stood before the same cycle's update, even when the guard is also one of that compare's destinations.
- R10: qry_disjoint_o is a combinational function of qry_a_i, qry_b_i and the registered matrix. It can be read in the same cycle the query is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid_i | input | 1 | A compare event is presented this cycle |
| cmp_guard_i | input | $clog2(PREDS) | Guarding predicate register; 0 means unguarded |
| cmp_dst_a_i | input | $clog2(PREDS) | First destination predicate register |
| cmp_dst_b_i | input | $clog2(PREDS) | Second destination predicate register |
| qry_a_i | input | $clog2(ENTRIES) | First path entry of the query |
| qry_b_i | input | $clog2(ENTRIES) | Second path entry of the query |
| qry_disjoint_o | output | 1 | Queried entries are mutually exclusive |
| alloc_a_o | output | $clog2(ENTRIES) | Entry assigned to destination a |
| alloc_b_o | output | $clog2(ENTRIES) | Entry assigned to destination b |

## Verification
The block is driven with several compare shapes:
- an unguarded pair;
- a two-level and a three-level nest of guarded compares;
- guards on predicate 0 and on a register that was never defined;
- a compare that writes predicate 0;
- back-to-back compares where the guard is written in the previous cycle or in the same cycle.

Each shape separates a different behaviour: plain complement marking, transitive inheritance, the unguarded fallback, and the ordering of the map read against its write. A long back-to-back run then wraps the allocator several times. Some guards in that run point at entries that are being reassigned. After each phase the whole matrix is swept through the query port and compared with a behavioural model. This catches stale columns, lost symmetry and wrong inheritance.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
    localparam int unsigned PDT_DEF_ENTRIES = 16;
    localparam int unsigned PDT_DEF_PREDS   = 64;
endpackage

// File: rtl/pdt_alloc.sv
module pdt_alloc #(
    parameter int unsigned ENTRIES = pdt_pkg::PDT_DEF_ENTRIES,
    localparam int unsigned EW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    output logic [EW-1:0] ent_a_o,
    output logic [EW-1:0] ent_b_o
);
    typedef struct packed {
        logic [EW-1:0] ptr;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_i) st_d.ptr = st_q.ptr + EW'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_a_o = st_q.ptr;
    assign ent_b_o = {st_q.ptr[EW-1:1], 1'b1};

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> st_q.ptr == $past(st_q.ptr) + EW'(2));
    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(st_q.ptr));
    // R2
    ptr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ptr[0]);
endmodule

// File: rtl/pdt_ldt.sv
module pdt_ldt #(
    parameter int unsigned ENTRIES = pdt_pkg::PDT_DEF_ENTRIES,
    parameter int unsigned PREDS   = pdt_pkg::PDT_DEF_PREDS,
    localparam int unsigned EW     = $clog2(ENTRIES),
    localparam int unsigned PW     = $clog2(PREDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [PW-1:0] guard_i,
    input  logic [PW-1:0] dst_a_i,
    input  logic [PW-1:0] dst_b_i,
    input  logic [EW-1:0] ent_a_i,
    input  logic [EW-1:0] ent_b_i,
    output logic          guard_hit_o,
    output logic [EW-1:0] guard_ent_o
);
    typedef struct packed {
        logic [PREDS-1:0][EW-1:0] map;
        logic [PREDS-1:0]         vld;
    } ldt_st_t;

    ldt_st_t st_d, st_q;

    // Guard lookup reads only the registered map (state before this cycle's write)
    assign guard_hit_o = (guard_i != '0) && st_q.vld[guard_i];
    assign guard_ent_o = st_q.map[guard_i];

    always_comb begin
        st_d = st_q;
        if (upd_i) begin
            if (dst_a_i != '0) begin
                st_d.map[dst_a_i] = ent_a_i;
                st_d.vld[dst_a_i] = 1'b1;
            end
            if (dst_b_i != '0) begin
                st_d.map[dst_b_i] = ent_b_i;
                st_d.vld[dst_b_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    ldt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && dst_b_i != '0) |=>
            st_q.vld[$past(dst_b_i)] && st_q.map[$past(dst_b_i)] == $past(ent_b_i));
    // R7
    p0_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[0]);
    // R8
    p0_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_i == '0) |-> !guard_hit_o);
endmodule

// File: rtl/pdt_matrix.sv
module pdt_matrix #(
    parameter int unsigned ENTRIES = pdt_pkg::PDT_DEF_ENTRIES,
    localparam int unsigned EW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_i,
    input  logic [EW-1:0] ent_a_i,
    input  logic [EW-1:0] ent_b_i,
    input  logic          inh_en_i,
    input  logic [EW-1:0] inh_ent_i,
    input  logic [EW-1:0] qry_a_i,
    input  logic [EW-1:0] qry_b_i,
    output logic          disj_o
);
    typedef struct packed {
        logic [ENTRIES-1:0][ENTRIES-1:0] row;
    } mtx_st_t;

    mtx_st_t st_d, st_q;
    logic [ENTRIES-1:0] pair_m;
    logic [ENTRIES-1:0] inh_v;

    always_comb begin
        st_d   = st_q;
        pair_m = '0;
        pair_m[ent_a_i] = 1'b1;
        pair_m[ent_b_i] = 1'b1;
        inh_v  = inh_en_i ? (st_q.row[inh_ent_i] & ~pair_m) : '0;
        if (upd_i) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                st_d.row[i] = st_q.row[i] & ~pair_m;
                if (inh_v[i]) st_d.row[i] = st_d.row[i] | pair_m;
            end
            st_d.row[ent_a_i]          = inh_v;
            st_d.row[ent_a_i][ent_b_i] = 1'b1;
            st_d.row[ent_b_i]          = inh_v;
            st_d.row[ent_b_i][ent_a_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign disj_o = st_q.row[qry_a_i][qry_b_i];

    // R3
    pair_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> st_q.row[$past(ent_a_i)][$past(ent_b_i)]
               && st_q.row[$past(ent_b_i)][$past(ent_a_i)]);
    // R4
    inherit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && inh_en_i && qry_a_i != ent_a_i && qry_a_i != ent_b_i
               && st_q.row[inh_ent_i][qry_a_i])
            |=> st_q.row[$past(ent_a_i)][$past(qry_a_i)]);
    // R5
    diag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.row[qry_a_i][qry_a_i]);
    // R5
    symmetric_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.row[qry_a_i][qry_b_i] == st_q.row[qry_b_i][qry_a_i]);
endmodule

// File: rtl/pred_disjoint_table.sv
module pred_disjoint_table #(
    parameter int unsigned ENTRIES = pdt_pkg::PDT_DEF_ENTRIES,
    parameter int unsigned PREDS   = pdt_pkg::PDT_DEF_PREDS,
    localparam int unsigned EW     = $clog2(ENTRIES),
    localparam int unsigned PW     = $clog2(PREDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_valid_i,
    input  logic [PW-1:0] cmp_guard_i,
    input  logic [PW-1:0] cmp_dst_a_i,
    input  logic [PW-1:0] cmp_dst_b_i,
    input  logic [EW-1:0] qry_a_i,
    input  logic [EW-1:0] qry_b_i,
    output logic          qry_disjoint_o,
    output logic [EW-1:0] alloc_a_o,
    output logic [EW-1:0] alloc_b_o
);
    logic          guard_hit;
    logic [EW-1:0] guard_ent;

    pdt_alloc #(.ENTRIES(ENTRIES)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (cmp_valid_i),
        .ent_a_o (alloc_a_o),
        .ent_b_o (alloc_b_o)
    );

    pdt_ldt #(.ENTRIES(ENTRIES), .PREDS(PREDS)) u_ldt (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_i       (cmp_valid_i),
        .guard_i     (cmp_guard_i),
        .dst_a_i     (cmp_dst_a_i),
        .dst_b_i     (cmp_dst_b_i),
        .ent_a_i     (alloc_a_o),
        .ent_b_i     (alloc_b_o),
        .guard_hit_o (guard_hit),
        .guard_ent_o (guard_ent)
    );

    pdt_matrix #(.ENTRIES(ENTRIES)) u_mtx (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (cmp_valid_i),
        .ent_a_i   (alloc_a_o),
        .ent_b_i   (alloc_b_o),
        .inh_en_i  (guard_hit),
        .inh_ent_i (guard_ent),
        .qry_a_i   (qry_a_i),
        .qry_b_i   (qry_b_i),
        .disj_o    (qry_disjoint_o)
    );
endmodule

// File: tb/sim_pred_disjoint_table.sv
module sim_pred_disjoint_table;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 16;
    localparam int NP = 64;
    localparam int EW = $clog2(NE);
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmp_valid = 1'b0;
    logic [PW-1:0] cmp_guard = '0;
    logic [PW-1:0] cmp_dst_a = '0;
    logic [PW-1:0] cmp_dst_b = '0;
    logic [EW-1:0] qry_a = '0;
    logic [EW-1:0] qry_b = '0;
    logic          qry_disjoint;
    logic [EW-1:0] alloc_a, alloc_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit rm[NE][NE];
    int rldt[NP];
    int rptr;

    always #(CLK_PERIOD/2) clk = ~clk;

    pred_disjoint_table #(.ENTRIES(NE), .PREDS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid_i(cmp_valid),
        .cmp_guard_i(cmp_guard), .cmp_dst_a_i(cmp_dst_a), .cmp_dst_b_i(cmp_dst_b),
        .qry_a_i(qry_a), .qry_b_i(qry_b), .qry_disjoint_o(qry_disjoint),
        .alloc_a_o(alloc_a), .alloc_b_o(alloc_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural model of one accepted compare
    task automatic model_cmp(input int g, input int da, input int db);
        int ea = rptr;
        int eb = rptr + 1;
        int src = -1;
        bit inh[NE];
        if (g != 0 && rldt[g] >= 0) src = rldt[g];
        for (int k = 0; k < NE; k++) inh[k] = (src >= 0) ? rm[src][k] : 1'b0;
        inh[ea] = 0; inh[eb] = 0;
        for (int k = 0; k < NE; k++) begin
            rm[ea][k] = 0; rm[k][ea] = 0; rm[eb][k] = 0; rm[k][eb] = 0;
        end
        for (int k = 0; k < NE; k++) if (inh[k]) begin
            rm[ea][k] = 1; rm[k][ea] = 1; rm[eb][k] = 1; rm[k][eb] = 1;
        end
        rm[ea][eb] = 1; rm[eb][ea] = 1;
        if (da != 0) rldt[da] = ea;
        if (db != 0) rldt[db] = eb;
        rptr = (rptr + 2) % NE;
    endtask

    task automatic do_cmp(input int g, input int da, input int db);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_guard = PW'(g); cmp_dst_a = PW'(da); cmp_dst_b = PW'(db);
        #1;
        chk(alloc_a == EW'(rptr), "R2 alloc_a", int'(alloc_a), rptr);
        chk(alloc_b == EW'(rptr + 1), "R2 alloc_b", int'(alloc_b), rptr + 1);
        @(posedge clk);
        model_cmp(g, da, db);
    endtask

    task automatic idle();
        @(negedge clk);
        cmp_valid = 1'b0;
        cmp_guard = '0; cmp_dst_a = '0; cmp_dst_b = '0;
    endtask

    // Full matrix sweep through the combinational query port (R10, R5)
    task automatic sweep(input string tag);
        for (int i = 0; i < NE; i++) begin
            for (int j = 0; j < NE; j++) begin
                qry_a = EW'(i); qry_b = EW'(j);
                #1;
                chk(qry_disjoint == rm[i][j],
                    $sformatf("%s R10 q(%0d,%0d)", tag, i, j), int'(qry_disjoint), int'(rm[i][j]));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) for (int j = 0; j < NE; j++) rm[i][j] = 0;
        for (int p = 0; p < NP; p++) rldt[p] = -1;
        rptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(alloc_a == 0, "R1 alloc_a", int'(alloc_a), 0);
        chk(alloc_b == 1, "R1 alloc_b", int'(alloc_b), 1);
        sweep("R1");

        // R3: unguarded pair
        do_cmp(0, 2, 3);
        idle(); sweep("R3");

        // R4: nested guarded compares
        do_cmp(3, 4, 5);
        idle(); sweep("R4 level2");
        do_cmp(4, 6, 7);
        idle(); sweep("R4 level3");

        // R8: guard on predicate 0 and on an undefined predicate
        do_cmp(0, 8, 9);
        do_cmp(40, 10, 11);
        idle(); sweep("R8");

        // R7: predicate 0 as destination is not recorded; p12 then used as guard
        do_cmp(0, 0, 12);
        do_cmp(12, 13, 14);
        do_cmp(0, 15, 15);
        do_cmp(15, 16, 17);
        idle(); sweep("R7");

        // R9: guard written the previous cycle, and guard written by the same compare
        do_cmp(7, 6, 18);
        do_cmp(18, 19, 20);
        do_cmp(6, 6, 21);
        idle(); sweep("R9");
        do_cmp(6, 22, 23);
        idle(); sweep("R9 after");

        // R6: long back-to-back run wrapping the allocator
        for (int k = 0; k < 24; k++) begin
            int g = (k % 3 == 0) ? 0 : 24 + ((k * 7) % 20);
            do_cmp(g, 24 + ((2 * k) % 20), 25 + ((2 * k) % 20));
        end
        idle(); sweep("R6");
        idle();
        chk(alloc_a == EW'(rptr), "R2 hold", int'(alloc_a), rptr);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule